// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block sits beside the register file of an 8250-style serial port and turns four pending interrupt sources into the value software reads from the interrupt identification register and into a level-sensitive interrupt request. The four sources are line status, receive data, transmit empty and modem status. Each source has its own set strobe and its own clear strobe. A 4-bit enable register selects which pending sources are allowed to take part.

A fixed priority picks one winner among the enabled pending sources. The winner is tracked as an enumerated selection with five values: SRC_NONE, SRC_LINE, SRC_RXD, SRC_TXE and SRC_MDM. The selection has no sequential transitions of its own. It is re-evaluated every cycle from the registered pending bits and the registered enable bits, so a set, clear or enable change shows at the outputs in the cycle after the strobe. A read of the identification register while it reports transmit-empty consumes that source. The modem-control OUT2 bit gates the request line. The FIFO-enable bit marks the upper two bits of the read value.

Top module: `uart_int_ident`

## Requirements
- R1: A write to the enable register stores only data bits 3:0, with bit 0 for receive, bit 1 for transmit-empty, bit 2 for line status and bit 3 for modem status. Data bits 7:4 have no effect.
- R2: Among enabled pending sources, line status wins over receive, receive wins over transmit-empty, and transmit-empty wins over modem status.
- R3: Identification bits 3:0 read 6 for line status, 4 for receive, 2 for transmit-empty and 0 for modem status.
- R4: Identification bits 3:0 read 1 when no enabled source is pending.
- R5: `irq` is high exactly when an enabled source is pending and `out2` is high.
- R6: A read strobe while bits 3:1 of the identification value equal 1 (code 2) clears the transmit-empty pending bit.
- R7: A read strobe while any other code is reported leaves every pending bit unchanged.
- R8: A set strobe wins over a clear strobe or a read-clear in the same cycle, so the source stays pending.
- R9: With `fifo_en` high, identification bits 7:6 read 2'b11. Otherwise they read 2'b00. Bits 5:4 always read 0.
- R10: A source becomes pending when its set strobe is high even if it is disabled, and it is reported once it is enabled.
- R11: A clear strobe alone removes its source from pending in the next cycle.
- R12: After reset the enable register and all pending bits are zero, so the identification value is 1 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| src_set | input | 4 | Per-source set strobes (0 rx, 1 tx, 2 line, 3 modem) |
| src_clr | input | 4 | Per-source clear strobes, same bit order |
| iir_rd | input | 1 | Identification register read strobe |
| out2 | input | 1 | Modem-control OUT2 bit |
| fifo_en | input | 1 | FIFO-control enable bit |
| iir_value | output | 8 | Identification register value |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land in the same cycle: the read-clear of transmit-empty and a fresh transmit-empty set strobe. The bench provokes this by asserting the read strobe while code 2 is shown and raising the transmit set strobe in the same cycle. It then expects code 2 to remain on the next cycle. A reference model, written from the requirements, predicts the identification value and request every cycle. It also covers a plain clear against a set on the same source.

// File: rtl/uii_pkg.sv
package uii_pkg;
    localparam int NUM_SRC = 4;
    localparam int IDX_RXD = 0;
    localparam int IDX_TXE = 1;
    localparam int IDX_LINE = 2;
    localparam int IDX_MDM = 3;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_LINE,
        SRC_RXD,
        SRC_TXE,
        SRC_MDM
    } src_e;

    localparam logic [3:0] CODE_NONE = 4'd1;
    localparam logic [3:0] CODE_LINE = 4'd6;
    localparam logic [3:0] CODE_RXD = 4'd4;
    localparam logic [3:0] CODE_TXE = 4'd2;
    localparam logic [3:0] CODE_MDM = 4'd0;
endpackage

// File: rtl/uii_enable_reg.sv
module uii_enable_reg #(
    parameter int DATA_W = 8,
    parameter int EN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [EN_W-1:0]   en_q
);
    logic unused_hi;
    assign unused_hi = ^wdata[DATA_W-1:EN_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr) begin
            en_q <= wdata[EN_W-1:0];
        end
    end

    // R1: only the low bits are kept
    p_ier_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> en_q == $past(wdata[EN_W-1:0]));
endmodule

// File: rtl/uii_pending.sv
module uii_pending #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_q
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                pend_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                pend_q[i] <= 1'b0;
            end
        end

        // R8: a set strobe always leaves the source pending
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> pend_q[i]);
        // R11: a clear strobe alone drops the source
        p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !pend_q[i]);
    end
endmodule

// File: rtl/uii_prio.sv
module uii_prio
    import uii_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    output src_e               win
);
    logic [NUM_SRC-1:0] hit;
    assign hit = pend & en;

    always_comb begin
        if (hit[IDX_LINE]) begin
            win = SRC_LINE;
        end else if (hit[IDX_RXD]) begin
            win = SRC_RXD;
        end else if (hit[IDX_TXE]) begin
            win = SRC_TXE;
        end else if (hit[IDX_MDM]) begin
            win = SRC_MDM;
        end else begin
            win = SRC_NONE;
        end
    end
endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
    import uii_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ier_wr,
    input  logic [DATA_W-1:0] ier_wdata,
    input  logic [3:0]        src_set,
    input  logic [3:0]        src_clr,
    input  logic              iir_rd,
    input  logic              out2,
    input  logic              fifo_en,
    output logic [DATA_W-1:0] iir_value,
    output logic              irq
);
    localparam int PAD_W = DATA_W - 6;

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] clr_all;
    logic [3:0]         code;
    logic               txe_rd_clr;
    src_e               win;

    uii_enable_reg #(.DATA_W(DATA_W), .EN_W(NUM_SRC)) u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ier_wr),
        .wdata (ier_wdata),
        .en_q  (en_q)
    );

    uii_prio u_prio (
        .pend (pend_q),
        .en   (en_q),
        .win  (win)
    );

    always_comb begin
        unique case (win)
            SRC_LINE: code = CODE_LINE;
            SRC_RXD:  code = CODE_RXD;
            SRC_TXE:  code = CODE_TXE;
            SRC_MDM:  code = CODE_MDM;
            SRC_NONE: code = CODE_NONE;
            default:  code = CODE_NONE;
        endcase
    end

    assign txe_rd_clr = iir_rd && (code[3:1] == 3'd1);

    always_comb begin
        clr_all = src_clr;
        clr_all[IDX_TXE] = src_clr[IDX_TXE] | txe_rd_clr;
    end

    uii_pending #(.N(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_set),
        .clr_i  (clr_all),
        .pend_q (pend_q)
    );

    assign iir_value = {{2{fifo_en}}, {PAD_W{1'b0}}, code};
    assign irq = out2 && (win != SRC_NONE);

    // R6: a read while transmit-empty is shown consumes it
    p_txe_rd_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_value[3:0] == CODE_TXE && !src_set[IDX_TXE]) |=> !pend_q[IDX_TXE]);
    // R7: a read under another code leaves pending bits alone
    p_rd_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_value[3:0] != CODE_TXE && src_set == '0 && src_clr == '0)
        |=> pend_q == $past(pend_q));
    // R4: idle code never comes with a request
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_value[3:0] == CODE_NONE) |-> !irq);
    // R5: request needs an enabled pending source
    p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend_q & en_q) != '0);
endmodule

// File: tb/uart_int_ident_tb.sv
module uart_int_ident_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 1'b0;
    logic [7:0] ier_wdata = '0;
    logic [3:0] src_set = '0;
    logic [3:0] src_clr = '0;
    logic       iir_rd = 1'b0;
    logic       out2 = 1'b0;
    logic       fifo_en = 1'b0;
    logic [7:0] iir_value;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] m_pend = '0;
    logic [3:0] m_ier = '0;

    always #5 clk = ~clk;

    uart_int_ident u_dut (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .src_set(src_set), .src_clr(src_clr), .iir_rd(iir_rd),
        .out2(out2), .fifo_en(fifo_en), .iir_value(iir_value), .irq(irq)
    );

    function automatic logic [3:0] m_code();
        logic [3:0] h;
        h = m_pend & m_ier;
        if (h[2]) return 4'd6;
        if (h[0]) return 4'd4;
        if (h[1]) return 4'd2;
        if (h[3]) return 4'd0;
        return 4'd1;
    endfunction

    task automatic compare(input string tag);
        logic [7:0] exp_v;
        logic exp_irq;
        exp_v = {fifo_en, fifo_en, 2'b00, m_code()};
        exp_irq = out2 && (m_code() != 4'd1);
        n_cmp++;
        if (iir_value !== exp_v || irq !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: iir=%h irq=%b expected iir=%h irq=%b",
                     tag, iir_value, irq, exp_v, exp_irq);
        end
    endtask

    task automatic cyc(input logic wr, input logic [7:0] wd, input logic [3:0] st,
                       input logic [3:0] cl, input logic rd, input logic o2,
                       input logic fe, input string tag);
        logic rdclr;
        @(negedge clk);
        ier_wr = wr; ier_wdata = wd; src_set = st; src_clr = cl;
        iir_rd = rd; out2 = o2; fifo_en = fe;
        #1;
        compare(tag);
        rdclr = rd && (m_code() == 4'd2);
        for (int i = 0; i < 4; i++) begin
            if (st[i]) m_pend[i] = 1'b1;
            else if (cl[i] || (i == 1 && rdclr)) m_pend[i] = 1'b0;
        end
        if (wr) m_ier = wd[3:0];
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R12 reset");
        rst_n = 1'b1;
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 0, "R12 after reset");
        // R1: upper data bits ignored; R10: pending while disabled
        cyc(1, 8'hF0, 4'hF, 4'h0, 0, 1, 0, "R1 write F0");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 0, "R1 nothing enabled");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 0, "R4 idle code");
        // R10: enable one by one
        cyc(1, 8'h08, 4'h0, 4'h0, 0, 1, 0, "R10 enable modem");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 0, "R3 modem code");
        cyc(1, 8'h0F, 4'h0, 4'h0, 0, 1, 0, "R2 enable all");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 0, "R2 line first");
        cyc(0, 8'h00, 4'h0, 4'h4, 1, 1, 0, "R7 read under line");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 0, "R11 line cleared");
        cyc(0, 8'h00, 4'h0, 4'h1, 0, 1, 0, "R2 rx next");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 0, "R3 tx code");
        // R8: read-clear and set in the same cycle
        cyc(0, 8'h00, 4'h2, 4'h0, 1, 1, 0, "R8 set vs read");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 0, "R8 tx kept");
        cyc(0, 8'h00, 4'h0, 4'h0, 1, 1, 0, "R6 read tx");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 0, "R6 tx gone");
        cyc(0, 8'h00, 4'h0, 4'h0, 1, 1, 0, "R7 read under modem");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 0, 0, "R5 out2 low");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 1, "R9 fifo on");
        cyc(0, 8'h00, 4'h8, 4'h8, 0, 1, 1, "R8 set vs clear");
        cyc(0, 8'h00, 4'h0, 4'h8, 0, 1, 0, "R11 clear modem");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 0, "R4 empty again");
        // R2 pairwise orderings
        cyc(0, 8'h00, 4'h3, 4'h0, 0, 1, 0, "R2 set rx tx");
        cyc(0, 8'h00, 4'h8, 4'h0, 0, 1, 0, "R2 rx over tx");
        cyc(0, 8'h00, 4'h0, 4'h1, 0, 0, 1, "R5 gated");
        cyc(0, 8'h00, 4'h0, 4'h2, 0, 1, 0, "R2 tx over modem");
        cyc(1, 8'hF7, 4'h4, 4'h0, 0, 1, 0, "R1 disable modem");
        cyc(0, 8'h00, 4'h0, 4'h4, 0, 1, 0, "R3 line code");
        cyc(0, 8'h00, 4'h0, 4'h0, 0, 1, 0, "R5 disabled pending");
        for (int k = 0; k < 40; k++) begin
            cyc(k[0], {4'hA, k[5:2]}, k[3:0] ^ 4'h5, k[4:1], k[1], k[2], k[3], "R2 mixed");
        end
        @(negedge clk);
        #1;
        compare("R5 final");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule